// File: doc/BRIEF.md
# Three-Way Translation Buffer with Per-Mode Page Size

This block turns virtual addresses into physical addresses through a three-way set-associative table of 128 sets. Each entry maps one page. No entry carries its own page size. The page size comes from two small configuration registers, one for privileged (kernel) accesses and one for user accesses. Every lookup made in a mode uses that mode's size both to pick the set and to split the address into page offset and page number.

The block has two ports. The lookup port accepts a virtual address, a mode bit and an 8-bit address-space identifier. It reads the indexed set in all three ways at once and returns hit, way and physical address two clock edges later.

The management port carries three operations: probe, read and write. The caller always names the location. A write takes its set from a supplied virtual address and its way from a 2-bit selector. A read takes set and way directly. A probe reports where a match lives or that nothing matches. No entry is ever chosen by chance.

Top module: `modepage_tlb`

## Requirements
- R1: After reset every entry is invalid, both page-size registers hold code 0 (4 kB), and `lk_done`, `lk_hit`, `mg_done` and `mg_miss` are low. A lookup or probe issued after reset misses.
- R2: A lookup presented with `lk_req` high at clock edge N gives `lk_done` high, together with `lk_hit`, `lk_way` and `lk_pa`, after edge N+2. `lk_done` stays low otherwise.
- R3: The page-size codes are 0=4 kB, 1=8 kB, 2=16 kB, 3=64 kB, 4=1 MB, 5=4 MB and 6=16 MB. A configuration write with code 7 leaves the addressed register unchanged.
- R4: The kernel register and the user register are written independently: `cfg_kern`=1 selects kernel and 0 selects user. Each access uses the register chosen by its own mode bit.
- R5: The set index is the 7 virtual-address bits directly above the page offset of the active page size.
- R6: A way hits only when all of the following hold:
  - the entry is valid;
  - the virtual-address bits above the index match the stored page number;
  - either the entry is global or its stored identifier equals the request's identifier.
- R7: On a hit, `lk_pa` takes its bits at and above the page shift from the stored frame number (frame number times 4 kB), and the bits below the page shift pass through from the virtual address.
- R8: When more than one way hits, the lowest-numbered way is reported.
- R9: A write stores the page number, identifier, global flag, frame number and valid flag at the set given by `mg_va` under the page size of `mg_kern`'s mode, in way `mg_way`. Way-select 3 changes no entry.
- R10: A read returns the entry and its valid flag at `mg_set`, way `mg_way`. Way-select 3 returns all zeros.
- R11: A probe reports the lowest hitting way in `mg_hit_way` and the searched set in `mg_hit_set`, using the same match rules as a lookup. When no way matches it raises `mg_miss` instead.
- R12: Every management operation (op code 1=probe, 2=read, 3=write, 0=idle) gives a one-cycle `mg_done` after the second clock edge.
- R13: A lookup issued in the same cycle as a write to the entry it hits sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write a page-size register |
| cfg_kern | input | 1 | 1 selects the kernel register, 0 selects the user register |
| cfg_code | input | 3 | Page-size code to store |
| lk_req | input | 1 | Lookup request |
| lk_kern | input | 1 | Lookup mode, 1 = kernel |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a match |
| lk_way | output | 2 | Matching way |
| lk_pa | output | 36 | Translated physical address |
| mg_op | input | 2 | Management op: 0 idle, 1 probe, 2 read, 3 write |
| mg_kern | input | 1 | Mode whose page size a probe or write uses |
| mg_va | input | 32 | Virtual address for probe or write |
| mg_asid | input | 8 | Identifier for probe or write |
| mg_set | input | 7 | Set for read |
| mg_way | input | 2 | Way for read or write |
| mg_pfn | input | 24 | Frame number to write |
| mg_glob | input | 1 | Global flag to write |
| mg_valid | input | 1 | Valid flag to write |
| mg_done | output | 1 | Management op completed |
| mg_miss | output | 1 | Probe found no match |
| mg_hit_way | output | 2 | Way found by probe |
| mg_hit_set | output | 7 | Set searched by probe |
| mg_rd_vpn | output | 20 | Page number read |
| mg_rd_asid | output | 8 | Identifier read |
| mg_rd_glob | output | 1 | Global flag read |
| mg_rd_pfn | output | 24 | Frame number read |
| mg_rd_valid | output | 1 | Valid flag read |

## Verification
The hardest situation to reach is two ways of one set holding the same page at once, while a write and a lookup land on that set in the same cycle. Random traffic almost never produces either by chance. Directed steps therefore write one page into ways 2 and 1 and check that way 1 wins. They then issue a lookup and a write to the same slot together and check that the old frame comes back.

The random phase draws addresses from a small pool of pages and identifiers from a four-value range. It also changes both page-size codes along the way, reserved code included. Entries written under one size are therefore probed and looked up under another.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  parameter int VA_W      = 32;
  parameter int PA_W      = 36;
  parameter int ASID_W    = 8;
  parameter int MIN_SHIFT = 12;
  parameter int VPN_W     = VA_W - MIN_SHIFT;
  parameter int PFN_W     = PA_W - MIN_SHIFT;
  parameter int SHIFT_W   = 5;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_PROBE = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } mg_op_e;

  localparam logic [2:0] PG_RSVD = 3'd7;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn;
  } tlb_ent_t;

  // log2 of the page size in bytes for each code; 7 never reaches storage
  function automatic logic [SHIFT_W-1:0] pg_shift(input logic [2:0] code);
    case (code)
      3'd1:    pg_shift = 5'd13;
      3'd2:    pg_shift = 5'd14;
      3'd3:    pg_shift = 5'd16;
      3'd4:    pg_shift = 5'd20;
      3'd5:    pg_shift = 5'd22;
      3'd6:    pg_shift = 5'd24;
      default: pg_shift = 5'd12;
    endcase
  endfunction
endpackage

// File: rtl/tlbm_pgsize_regs.sv
module tlbm_pgsize_regs
  import tlbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic       cfg_kern,
  input  logic [2:0] cfg_code,
  output logic [2:0] kern_code,
  output logic [2:0] user_code
);
  logic code_ok;
  assign code_ok = (cfg_code != PG_RSVD);

  always_ff @(posedge clk) begin
    if (rst) begin
      kern_code <= 3'd0;
      user_code <= 3'd0;
    end else if (cfg_wr && code_ok) begin
      if (cfg_kern) kern_code <= cfg_code;
      else          user_code <= cfg_code;
    end
  end
endmodule

// File: rtl/tlbm_way_ram.sv
module tlbm_way_ram
  import tlbm_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output tlb_ent_t         a_ent,
  output logic             a_vld,
  input  logic [IDX_W-1:0] b_idx,
  input  logic             b_we,
  input  tlb_ent_t         b_wdata,
  input  logic             b_wvalid,
  output tlb_ent_t         b_ent,
  output logic             b_vld
);
  tlb_ent_t        mem [SETS];
  logic [SETS-1:0] vbits;

  // port A: lookup read, old data on collision
  always_ff @(posedge clk) begin
    a_ent <= mem[a_idx];
  end

  // port B: management read or write
  always_ff @(posedge clk) begin
    if (b_we) mem[b_idx] <= b_wdata;
    b_ent <= mem[b_idx];
  end

  // valid flags live in flops so reset clears them
  always_ff @(posedge clk) begin
    if (rst) begin
      vbits <= '0;
      a_vld <= 1'b0;
      b_vld <= 1'b0;
    end else begin
      a_vld <= vbits[a_idx];
      b_vld <= vbits[b_idx];
      if (b_we) vbits[b_idx] <= b_wvalid;
    end
  end
endmodule

// File: rtl/tlbm_match.sv
module tlbm_match
  import tlbm_pkg::*;
#(
  parameter int WAYS   = 3,
  parameter int IDX_W  = 7,
  parameter int WSEL_W = 2
) (
  input  tlb_ent_t [WAYS-1:0] ents,
  input  logic [WAYS-1:0]     vlds,
  input  logic [VA_W-1:0]     va,
  input  logic [SHIFT_W-1:0]  shift,
  input  logic [ASID_W-1:0]   asid,
  output logic                hit,
  output logic [WSEL_W-1:0]   way,
  output logic [PA_W-1:0]     pa
);
  logic [VPN_W-1:0] cmp_mask;
  logic [WAYS-1:0]  hitv;
  logic [PFN_W-1:0] sel_pfn;
  logic [PA_W-1:0]  off_mask;
  logic [VPN_W-1:0] va_vpn;

  assign va_vpn   = va[VA_W-1:MIN_SHIFT];
  assign cmp_mask = {VPN_W{1'b1}} << (int'(shift) - MIN_SHIFT + IDX_W);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitv[w] = vlds[w]
                   && (((ents[w].vpn ^ va_vpn) & cmp_mask) == '0)
                   && (ents[w].glob || (ents[w].asid == asid));
  end

  always_comb begin
    hit     = |hitv;
    way     = '0;
    sel_pfn = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hitv[i]) begin
        way     = WSEL_W'(i);
        sel_pfn = ents[i].pfn;
      end
    end
  end

  assign off_mask = (PA_W'(1) << shift) - PA_W'(1);
  assign pa = ({sel_pfn, {MIN_SHIFT{1'b0}}} & ~off_mask) | (PA_W'(va) & off_mask);
endmodule

// File: rtl/modepage_tlb.sv
module modepage_tlb
  import tlbm_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 3,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_kern,
  input  logic [2:0]        cfg_code,
  input  logic              lk_req,
  input  logic              lk_kern,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [WSEL_W-1:0] lk_way,
  output logic [PA_W-1:0]   lk_pa,
  input  logic [1:0]        mg_op,
  input  logic              mg_kern,
  input  logic [VA_W-1:0]   mg_va,
  input  logic [ASID_W-1:0] mg_asid,
  input  logic [IDX_W-1:0]  mg_set,
  input  logic [WSEL_W-1:0] mg_way,
  input  logic [PFN_W-1:0]  mg_pfn,
  input  logic              mg_glob,
  input  logic              mg_valid,
  output logic              mg_done,
  output logic              mg_miss,
  output logic [WSEL_W-1:0] mg_hit_way,
  output logic [IDX_W-1:0]  mg_hit_set,
  output logic [VPN_W-1:0]  mg_rd_vpn,
  output logic [ASID_W-1:0] mg_rd_asid,
  output logic              mg_rd_glob,
  output logic [PFN_W-1:0]  mg_rd_pfn,
  output logic              mg_rd_valid
);
  logic [2:0] kern_code, user_code;

  tlbm_pgsize_regs u_pgsz (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_kern(cfg_kern),
    .cfg_code(cfg_code), .kern_code(kern_code), .user_code(user_code)
  );

  // ---------------- stage 0: index selection ----------------
  logic [SHIFT_W-1:0] lk_shift, mg_shift;
  logic [VA_W-1:0]    lk_sh_va, mg_sh_va;
  logic [IDX_W-1:0]   lk_idx, mg_va_idx, b_idx;

  assign lk_shift  = pg_shift(lk_kern ? kern_code : user_code);
  assign mg_shift  = pg_shift(mg_kern ? kern_code : user_code);
  assign lk_sh_va  = lk_va >> lk_shift;
  assign mg_sh_va  = mg_va >> mg_shift;
  assign lk_idx    = lk_sh_va[IDX_W-1:0];
  assign mg_va_idx = mg_sh_va[IDX_W-1:0];
  assign b_idx     = (mg_op == OP_READ) ? mg_set : mg_va_idx;

  tlb_ent_t wdata;
  assign wdata.vpn  = mg_va[VA_W-1:MIN_SHIFT];
  assign wdata.asid = mg_asid;
  assign wdata.glob = mg_glob;
  assign wdata.pfn  = mg_pfn;

  tlb_ent_t [WAYS-1:0] a_ents, b_ents;
  logic [WAYS-1:0]     a_vlds, b_vlds, b_we;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign b_we[w] = (mg_op == OP_WRITE) && (mg_way == WSEL_W'(w));
    tlbm_way_ram #(.SETS(SETS), .IDX_W(IDX_W)) u_ram (
      .clk(clk), .rst(rst),
      .a_idx(lk_idx), .a_ent(a_ents[w]), .a_vld(a_vlds[w]),
      .b_idx(b_idx), .b_we(b_we[w]), .b_wdata(wdata), .b_wvalid(mg_valid),
      .b_ent(b_ents[w]), .b_vld(b_vlds[w])
    );
  end

  // ---------------- stage 1: request context ----------------
  logic               s1_lk_req;
  logic [VA_W-1:0]    s1_lk_va;
  logic [SHIFT_W-1:0] s1_lk_shift;
  logic [ASID_W-1:0]  s1_lk_asid;
  logic [1:0]         s1_mg_op;
  logic [VA_W-1:0]    s1_mg_va;
  logic [SHIFT_W-1:0] s1_mg_shift;
  logic [ASID_W-1:0]  s1_mg_asid;
  logic [WSEL_W-1:0]  s1_mg_way;
  logic [IDX_W-1:0]   s1_mg_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_lk_req <= 1'b0;
      s1_mg_op  <= OP_NOP;
    end else begin
      s1_lk_req <= lk_req;
      s1_mg_op  <= mg_op;
    end
    s1_lk_va    <= lk_va;
    s1_lk_shift <= lk_shift;
    s1_lk_asid  <= lk_asid;
    s1_mg_va    <= mg_va;
    s1_mg_shift <= mg_shift;
    s1_mg_asid  <= mg_asid;
    s1_mg_way   <= mg_way;
    s1_mg_idx   <= b_idx;
  end

  logic              lk_m_hit, pr_m_hit;
  logic [WSEL_W-1:0] lk_m_way, pr_m_way;
  logic [PA_W-1:0]   lk_m_pa, pr_m_pa;

  tlbm_match #(.WAYS(WAYS), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_lk_match (
    .ents(a_ents), .vlds(a_vlds), .va(s1_lk_va), .shift(s1_lk_shift),
    .asid(s1_lk_asid), .hit(lk_m_hit), .way(lk_m_way), .pa(lk_m_pa)
  );

  tlbm_match #(.WAYS(WAYS), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_pr_match (
    .ents(b_ents), .vlds(b_vlds), .va(s1_mg_va), .shift(s1_mg_shift),
    .asid(s1_mg_asid), .hit(pr_m_hit), .way(pr_m_way), .pa(pr_m_pa)
  );

  tlb_ent_t rd_ent;
  logic     rd_vld;
  always_comb begin
    rd_ent = '0;
    rd_vld = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (s1_mg_way == WSEL_W'(w)) begin
        rd_ent = b_ents[w];
        rd_vld = b_vlds[w];
      end
    end
  end

  // ---------------- stage 2: registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_way  <= '0;
      lk_pa   <= '0;
    end else begin
      lk_done <= s1_lk_req;
      lk_hit  <= s1_lk_req && lk_m_hit;
      lk_way  <= (s1_lk_req && lk_m_hit) ? lk_m_way : '0;
      lk_pa   <= (s1_lk_req && lk_m_hit) ? lk_m_pa  : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mg_done     <= 1'b0;
      mg_miss     <= 1'b0;
      mg_hit_way  <= '0;
      mg_hit_set  <= '0;
      mg_rd_vpn   <= '0;
      mg_rd_asid  <= '0;
      mg_rd_glob  <= 1'b0;
      mg_rd_pfn   <= '0;
      mg_rd_valid <= 1'b0;
    end else begin
      mg_done     <= (s1_mg_op != OP_NOP);
      mg_miss     <= (s1_mg_op == OP_PROBE) && !pr_m_hit;
      mg_hit_way  <= ((s1_mg_op == OP_PROBE) && pr_m_hit) ? pr_m_way  : '0;
      mg_hit_set  <= ((s1_mg_op == OP_PROBE) && pr_m_hit) ? s1_mg_idx : '0;
      if (s1_mg_op == OP_READ) begin
        mg_rd_vpn   <= rd_ent.vpn;
        mg_rd_asid  <= rd_ent.asid;
        mg_rd_glob  <= rd_ent.glob;
        mg_rd_pfn   <= rd_ent.pfn;
        mg_rd_valid <= rd_vld;
      end else begin
        mg_rd_vpn   <= '0;
        mg_rd_asid  <= '0;
        mg_rd_glob  <= 1'b0;
        mg_rd_pfn   <= '0;
        mg_rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/modepage_tlb_chk.sv
module modepage_tlb_chk #(
  parameter int WAYS   = 3,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic              lk_done,
  input logic              lk_hit,
  input logic [WSEL_W-1:0] lk_way,
  input logic [1:0]        mg_op,
  input logic              mg_done,
  input logic              mg_miss,
  input logic [2:0]        kern_code,
  input logic [2:0]        user_code
);
  AST_LK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_req |-> ##2 lk_done); // R2
  AST_HIT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done); // R6
  AST_WAY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (int'(lk_way) < WAYS)); // R8
  AST_KCODE_NOT_RSVD: assert property (@(posedge clk) disable iff (rst)
    kern_code != 3'd7); // R3
  AST_UCODE_NOT_RSVD: assert property (@(posedge clk) disable iff (rst)
    user_code != 3'd7); // R3
  AST_MG_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (mg_op != 2'd0) |-> ##2 mg_done); // R12
  AST_MISS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    mg_miss |-> mg_done); // R11
endmodule

bind modepage_tlb modepage_tlb_chk #(.WAYS(WAYS), .WSEL_W(WSEL_W)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_done(lk_done), .lk_hit(lk_hit),
  .lk_way(lk_way), .mg_op(mg_op), .mg_done(mg_done), .mg_miss(mg_miss),
  .kern_code(kern_code), .user_code(user_code)
);

// File: tb/modepage_tlb_test.sv
`timescale 1ns/1ps
module modepage_tlb_test;
  import tlbm_pkg::*;
  localparam int SETS = 128, WAYS = 3, IDX_W = 7, WSEL_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic cfg_wr = 0, cfg_kern = 0; logic [2:0] cfg_code = 0;
  logic lk_req = 0, lk_kern = 0; logic [VA_W-1:0] lk_va = 0; logic [ASID_W-1:0] lk_asid = 0;
  logic lk_done, lk_hit; logic [WSEL_W-1:0] lk_way; logic [PA_W-1:0] lk_pa;
  logic [1:0] mg_op = 0; logic mg_kern = 0; logic [VA_W-1:0] mg_va = 0;
  logic [ASID_W-1:0] mg_asid = 0; logic [IDX_W-1:0] mg_set = 0; logic [WSEL_W-1:0] mg_way = 0;
  logic [PFN_W-1:0] mg_pfn = 0; logic mg_glob = 0, mg_valid = 0;
  logic mg_done, mg_miss; logic [WSEL_W-1:0] mg_hit_way; logic [IDX_W-1:0] mg_hit_set;
  logic [VPN_W-1:0] mg_rd_vpn; logic [ASID_W-1:0] mg_rd_asid; logic mg_rd_glob;
  logic [PFN_W-1:0] mg_rd_pfn; logic mg_rd_valid;

  modepage_tlb #(.SETS(SETS), .WAYS(WAYS)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_kern(cfg_kern), .cfg_code(cfg_code),
    .lk_req(lk_req), .lk_kern(lk_kern), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_way(lk_way), .lk_pa(lk_pa),
    .mg_op(mg_op), .mg_kern(mg_kern), .mg_va(mg_va), .mg_asid(mg_asid),
    .mg_set(mg_set), .mg_way(mg_way), .mg_pfn(mg_pfn), .mg_glob(mg_glob),
    .mg_valid(mg_valid), .mg_done(mg_done), .mg_miss(mg_miss),
    .mg_hit_way(mg_hit_way), .mg_hit_set(mg_hit_set), .mg_rd_vpn(mg_rd_vpn),
    .mg_rd_asid(mg_rd_asid), .mg_rd_glob(mg_rd_glob), .mg_rd_pfn(mg_rd_pfn),
    .mg_rd_valid(mg_rd_valid)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  logic [VPN_W-1:0]  m_vpn  [WAYS][SETS];
  logic [ASID_W-1:0] m_asid [WAYS][SETS];
  bit                m_glob [WAYS][SETS];
  logic [PFN_W-1:0]  m_pfn  [WAYS][SETS];
  bit                m_val  [WAYS][SETS];
  bit                m_wr   [WAYS][SETS];
  int kcode = 0, ucode = 0;

  function automatic int f_shift(int code);
    case (code)
      1: return 13; 2: return 14; 3: return 16;
      4: return 20; 5: return 22; 6: return 24;
      default: return 12;
    endcase
  endfunction

  function automatic int f_idx(logic [VA_W-1:0] va, bit kern);
    int sh = f_shift(kern ? kcode : ucode);
    return int'((64'(va) >> sh) % SETS);
  endfunction

  function automatic void f_look(input logic [VA_W-1:0] va, input bit kern,
                                 input logic [ASID_W-1:0] asid, output bit hit,
                                 output int way, output logic [63:0] pa, output int idx);
    int sh = f_shift(kern ? kcode : ucode);
    idx = f_idx(va, kern);
    hit = 0; way = 0; pa = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      logic [63:0] dv;
      dv = (64'(va[VA_W-1:12]) ^ 64'(m_vpn[w][idx])) >> (sh - 12 + IDX_W);
      if (m_val[w][idx] && dv == 0 && (m_glob[w][idx] || m_asid[w][idx] == asid)) begin
        hit = 1; way = w;
        pa = ((64'(m_pfn[w][idx]) << 12) & ~((64'd1 << sh) - 1)) | (64'(va) & ((64'd1 << sh) - 1));
      end
    end
  endfunction

  function automatic void m_put(logic [VA_W-1:0] va, bit kern, logic [ASID_W-1:0] asid,
                                int way, logic [PFN_W-1:0] pfn, bit glob, bit vld);
    int idx = f_idx(va, kern);
    if (way < WAYS) begin
      m_vpn[way][idx] = va[VA_W-1:12]; m_asid[way][idx] = asid;
      m_glob[way][idx] = glob; m_pfn[way][idx] = pfn;
      m_val[way][idx] = vld; m_wr[way][idx] = 1;
    end
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic t_cfg(input bit kern, input int code);
    @(negedge clk); cfg_wr = 1; cfg_kern = kern; cfg_code = 3'(code);
    @(negedge clk); cfg_wr = 0;
    if (code != 7) begin if (kern) kcode = code; else ucode = code; end
  endtask

  task automatic t_write(input logic [VA_W-1:0] va, input bit kern, input logic [ASID_W-1:0] asid,
                         input int way, input logic [PFN_W-1:0] pfn, input bit glob, input bit vld);
    m_put(va, kern, asid, way, pfn, glob, vld);
    @(negedge clk);
    mg_op = 2'd3; mg_va = va; mg_kern = kern; mg_asid = asid; mg_way = 2'(way);
    mg_pfn = pfn; mg_glob = glob; mg_valid = vld;
    @(negedge clk); mg_op = 2'd0;
    @(negedge clk);
    chk(mg_done == 1'b1, "R12 write done", 64'(mg_done), 1);
  endtask

  task automatic t_lookup(input logic [VA_W-1:0] va, input bit kern,
                          input logic [ASID_W-1:0] asid, input string rq);
    bit eh; int ew; logic [63:0] ep; int ei;
    f_look(va, kern, asid, eh, ew, ep, ei);
    @(negedge clk); lk_req = 1; lk_va = va; lk_kern = kern; lk_asid = asid;
    @(negedge clk); lk_req = 0;
    @(negedge clk);
    chk(lk_done == 1'b1, "R2 lookup done", 64'(lk_done), 1);
    chk(lk_hit == eh, {rq, " hit"}, 64'(lk_hit), 64'(eh));
    if (eh) begin
      chk(int'(lk_way) == ew, {rq, " way"}, 64'(lk_way), 64'(ew));
      chk(64'(lk_pa) == ep, {rq, " pa"}, 64'(lk_pa), ep);
    end
  endtask

  task automatic t_probe(input logic [VA_W-1:0] va, input bit kern,
                         input logic [ASID_W-1:0] asid, input string rq);
    bit eh; int ew; logic [63:0] ep; int ei;
    f_look(va, kern, asid, eh, ew, ep, ei);
    @(negedge clk); mg_op = 2'd1; mg_va = va; mg_kern = kern; mg_asid = asid;
    @(negedge clk); mg_op = 2'd0;
    @(negedge clk);
    chk(mg_done == 1'b1, "R12 probe done", 64'(mg_done), 1);
    chk(mg_miss == !eh, {rq, " miss"}, 64'(mg_miss), 64'(!eh));
    if (eh) begin
      chk(int'(mg_hit_way) == ew, {rq, " way"}, 64'(mg_hit_way), 64'(ew));
      chk(int'(mg_hit_set) == ei, {rq, " set"}, 64'(mg_hit_set), 64'(ei));
    end
  endtask

  task automatic t_read(input int set, input int way, input string rq);
    @(negedge clk); mg_op = 2'd2; mg_set = 7'(set); mg_way = 2'(way);
    @(negedge clk); mg_op = 2'd0;
    @(negedge clk);
    chk(mg_done == 1'b1, "R12 read done", 64'(mg_done), 1);
    if (way >= WAYS) begin
      chk({mg_rd_vpn, mg_rd_asid, mg_rd_glob, mg_rd_pfn, mg_rd_valid} == '0,
          {rq, " way3 zero"}, 64'(mg_rd_pfn), 0);
    end else begin
      chk(mg_rd_valid == m_val[way][set], {rq, " valid"}, 64'(mg_rd_valid), 64'(m_val[way][set]));
      if (m_wr[way][set]) begin
        chk(mg_rd_vpn == m_vpn[way][set], {rq, " vpn"}, 64'(mg_rd_vpn), 64'(m_vpn[way][set]));
        chk(mg_rd_asid == m_asid[way][set], {rq, " asid"}, 64'(mg_rd_asid), 64'(m_asid[way][set]));
        chk(mg_rd_glob == m_glob[way][set], {rq, " glob"}, 64'(mg_rd_glob), 64'(m_glob[way][set]));
        chk(mg_rd_pfn == m_pfn[way][set], {rq, " pfn"}, 64'(mg_rd_pfn), 64'(m_pfn[way][set]));
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VA_W-1:0] pool [8];
    void'($urandom(32'd20240611));
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SETS; s++) begin
        m_val[w][s] = 0; m_wr[w][s] = 0; m_glob[w][s] = 0;
        m_vpn[w][s] = '0; m_asid[w][s] = '0; m_pfn[w][s] = '0;
      end

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(lk_done == 0 && lk_hit == 0, "R1 lookup outputs idle", 64'(lk_done), 0);
    chk(mg_done == 0 && mg_miss == 0, "R1 mgmt outputs idle", 64'(mg_done), 0);
    t_lookup(32'h1234_5678, 0, 8'd5, "R1 empty lookup");
    t_probe(32'h1234_5678, 1, 8'd5, "R1 empty probe");

    // R3/R5/R7: 4 kB default user mapping
    t_write(32'h1234_5000, 0, 8'd5, 0, 24'hABCDE, 0, 1);
    t_lookup(32'h1234_5678, 0, 8'd5, "R7 4k translate");
    // R3: reserved code ignored
    t_cfg(0, 7);
    t_lookup(32'h1234_5678, 0, 8'd5, "R3 reserved code ignored");
    // R4: kernel to 1 MB, user unaffected
    t_cfg(1, 4);
    t_lookup(32'h1234_5678, 1, 8'd5, "R4 kernel size separate");
    t_lookup(32'h1234_5678, 0, 8'd5, "R4 user keeps 4k");
    // R5/R7: 1 MB kernel page
    t_write(32'h5550_0000, 1, 8'd9, 1, 24'h123456, 0, 1);
    t_lookup(32'h555A_BCDE, 1, 8'd9, "R7 1M translate");
    t_probe(32'h555F_0000, 1, 8'd9, "R11 probe hit");
    // R6: identifier mismatch and global bypass
    t_lookup(32'h555A_BCDE, 1, 8'd3, "R6 asid mismatch");
    t_write(32'h2220_0000, 1, 8'd1, 2, 24'h00F0F0, 1, 1);
    t_lookup(32'h2221_0004, 1, 8'd77, "R6 global bypass");
    // R8: same page in ways 2 and 1
    t_write(32'h0777_7000, 0, 8'd4, 2, 24'h000222, 0, 1);
    t_write(32'h0777_7000, 0, 8'd4, 1, 24'h000111, 0, 1);
    t_lookup(32'h0777_7ABC, 0, 8'd4, "R8 lowest way wins");
    t_probe(32'h0777_7ABC, 0, 8'd4, "R8 probe lowest way");
    // R9: way-select 3 ignored
    t_write(32'h0AAA_A000, 0, 8'd4, 3, 24'h000333, 0, 1);
    t_lookup(32'h0AAA_A000, 0, 8'd4, "R9 way3 write ignored");
    t_read(f_idx(32'h0AAA_A000, 0), 0, "R9 way0 untouched");
    // R10: reads
    t_read(f_idx(32'h0777_7000, 0), 2, "R10 read way2");
    t_read(f_idx(32'h0777_7000, 0), 3, "R10 read way3");
    // R9: invalidating write
    t_write(32'h0777_7000, 0, 8'd4, 1, 24'h000111, 0, 0);
    t_lookup(32'h0777_7ABC, 0, 8'd4, "R9 invalidate falls to way2");

    // R13: lookup and write to same entry in one cycle
    begin
      bit eh; int ew; logic [63:0] ep; int ei;
      f_look(32'h1234_5678, 0, 8'd5, eh, ew, ep, ei);
      @(negedge clk);
      lk_req = 1; lk_va = 32'h1234_5678; lk_kern = 0; lk_asid = 8'd5;
      mg_op = 2'd3; mg_va = 32'h1234_5000; mg_kern = 0; mg_asid = 8'd5; mg_way = 0;
      mg_pfn = 24'h055555; mg_glob = 0; mg_valid = 1;
      @(negedge clk); lk_req = 0; mg_op = 0;
      @(negedge clk);
      chk(lk_hit == eh, "R13 collision hit", 64'(lk_hit), 64'(eh));
      chk(64'(lk_pa) == ep, "R13 collision old pa", 64'(lk_pa), ep);
      m_put(32'h1234_5000, 0, 8'd5, 0, 24'h055555, 0, 1);
      t_lookup(32'h1234_5678, 0, 8'd5, "R13 new contents after");
    end

    // random phase
    for (int i = 0; i < 8; i++) pool[i] = $urandom;
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 10);
      logic [VA_W-1:0] va = pool[$urandom % 8] ^ VA_W'($urandom % 32'h4000);
      bit kern = 1'($urandom);
      logic [ASID_W-1:0] asid = ASID_W'($urandom % 4);
      if (op == 0) t_cfg(kern, int'($urandom % 8));
      else if (op < 4) t_write(va, kern, asid, int'($urandom % 4), PFN_W'($urandom),
                               1'($urandom % 4 == 0), 1'($urandom % 8 != 0));
      else if (op < 7) t_lookup(va, kern, asid, "R6 random lookup");
      else if (op < 9) t_probe(va, kern, asid, "R11 random probe");
      else t_read(int'($urandom % SETS), int'($urandom % 4), "R10 random read");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule